// File: doc/BRIEF.md
# BT.656 Digital Video Stream Generator

This block produces the 8-bit word stream that drives a digital video encoder running as a timing slave. It emits one word on each cycle of a 27 MHz clock. Each pixel takes two words in 4:2:2 form, so the active part of a line is a series of four-word groups in the order Cb, Y, Cr, Y. Sync is not carried on separate pins. Instead, each line holds two four-word timing codes: an end-of-active-video code (EAV) and a start-of-active-video code (SAV). Each code carries the field bit, the vertical-blanking bit and a horizontal flag, and these let the encoder rebuild the raster.

A word counter and a line counter step through an interlaced 525-line frame of 1716-word lines. The default raster has 1440 active words per line and 487 viewable lines, split over two fields. For each active group, the generator strobes a request to a frame-buffer reader one group ahead of time. The reader answers with a 32-bit packed group and a valid flag. If no answer arrives in time, that group is sent as blanking. The raster never waits for the frame buffer.

All raster sizes are parameters. This lets a short test raster be used with the same logic as the full NTSC frame.

Top module: `vid656_gen`

## Requirements
- R1: The word position runs 0 to LINE_WORDS-1 (default 1716) and then wraps. At each wrap the line number advances, and after line FRAME_LINES (default 525) it returns to 1. The outputs lineNum and wordNum always report the position of the word currently on vidData.
- R2: Words 0 to 3 of every line carry the EAV code. Words LINE_WORDS-ACT_WORDS-4 to LINE_WORDS-ACT_WORDS-1 carry the SAV code. Each code is the sequence 0xFF, 0x00, 0x00, XY. H is 1 in the EAV code and 0 in the SAV code.
- R3: The XY word is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 as the most significant bit.
- R4: F is 1 on lines below FIELD1_FIRST (default 4) and on lines from FIELD2_FIRST (default 266) onward; otherwise F is 0. V is 0 only on lines ACT1_FIRST to ACT1_LAST (default 20 to 263) and ACT2_FIRST to ACT2_LAST (default 283 to 525).
- R5: Every word that is neither a timing code nor delivered pixel data is a blanking word: 0x80 at an even word index and 0x10 at an odd one. This covers horizontal blanking and the whole active span of lines where V=1.
- R6: pixReq is high for exactly one cycle at word SAV_POS+4k, for k from 0 to ACT_WORDS/4-1, on lines where V=0 only. SAV_POS is LINE_WORDS-ACT_WORDS-4 and is a multiple of 4. pixReq is never high anywhere else.
- R7: pixValid is accepted if it is high in the request cycle or in any of the three cycles after it. The accepted pixData is then sent in the next group, in the order [31:24] Cb, [23:16] Y, [15:8] Cr, [7:0] Y.
- R8: If no pixValid arrives in the four-cycle window after a request, the following group carries blanking words. Line and word timing are not affected.
- R9: pixValid outside every request window has no effect on vidData.
- R10: While the synchronous reset rst is high, the position is line 1, word 0, vidData is 0xFF and pixReq is low. The first word after rst falls is the start of a complete line 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz word clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Frame-buffer answer valid |
| pixData | input | 32 | Packed group: Cb, Y, Cr, Y from the most significant byte down |
| pixReq | output | 1 | One-cycle request for the next active group |
| vidData | output | 8 | Video word stream |
| lineNum | output | LINE_W (10) | Line of the current word, counted from 1 |
| wordNum | output | WORD_W (11) | Word index of the current word within the line |

## Verification
A wrong counter state shows at the ports on the very next word. wordNum or lineNum leaves the expected sequence, and either a timing code appears at the wrong index or an XY word carries the wrong F, V or parity bits. A fault in the request bookkeeping shows within one group. Either pixReq lands off its four-word grid, or a group shows data that was never requested, or shows blanking where an answer did arrive. To cover these, the bench runs whole frames of a small raster under several answer delays and under missing, partial and unsolicited answers.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  // Strobes handed from the raster control to the word datapath.
  typedef struct packed {
    logic       syncEav;     // inside the end-of-active code
    logic       syncSav;     // inside the start-of-active code
    logic       actSpan;     // inside the active word span of the line
    logic       lineActive;  // line carries picture (V = 0)
    logic       fieldBit;    // F
    logic       reqSlot;     // first word of the group before an active group
    logic       groupEnd;    // last word of a four-word group
    logic [1:0] sub;         // position inside the group
  } vidStrobe_t;

  localparam logic [7:0] BLANK_CHROMA = 8'h80;
  localparam logic [7:0] BLANK_LUMA   = 8'h10;

  // Fourth word of a timing code, with its protection bits.
  function automatic logic [7:0] timingWord(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vid656_ctrl.sv
module vid656_ctrl import vid656_pkg::*; #(
  parameter int LINE_WORDS   = 1716,
  parameter int ACT_WORDS    = 1440,
  parameter int FRAME_LINES  = 525,
  parameter int FIELD1_FIRST = 4,
  parameter int FIELD2_FIRST = 266,
  parameter int ACT1_FIRST   = 20,
  parameter int ACT1_LAST    = 263,
  parameter int ACT2_FIRST   = 283,
  parameter int ACT2_LAST    = 525,
  parameter int WORD_W       = $clog2(LINE_WORDS),
  parameter int LINE_W       = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output vidStrobe_t        strb,
  output logic [LINE_W-1:0] lineNum,
  output logic [WORD_W-1:0] wordNum
);

  localparam logic [WORD_W-1:0] W_ONE     = WORD_W'(1);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);
  localparam logic [WORD_W-1:0] EAV_END   = WORD_W'(4);
  localparam logic [WORD_W-1:0] SAV_POS   = WORD_W'(LINE_WORDS - ACT_WORDS - 4);
  localparam logic [WORD_W-1:0] ACT_POS   = WORD_W'(LINE_WORDS - ACT_WORDS);
  localparam logic [WORD_W-1:0] LAST_REQ  = WORD_W'(LINE_WORDS - 8);

  localparam logic [LINE_W-1:0] L_ONE  = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_LAST = LINE_W'(FRAME_LINES);
  localparam logic [LINE_W-1:0] L_F1   = LINE_W'(FIELD1_FIRST);
  localparam logic [LINE_W-1:0] L_F2   = LINE_W'(FIELD2_FIRST);
  localparam logic [LINE_W-1:0] L_A1F  = LINE_W'(ACT1_FIRST);
  localparam logic [LINE_W-1:0] L_A1L  = LINE_W'(ACT1_LAST);
  localparam logic [LINE_W-1:0] L_A2F  = LINE_W'(ACT2_FIRST);
  localparam logic [LINE_W-1:0] L_A2L  = LINE_W'(ACT2_LAST);

  // Raster counters: word within line, line within frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      wordNum <= '0;
      lineNum <= L_ONE;
    end else if (wordNum == LAST_WORD) begin
      wordNum <= '0;
      lineNum <= (lineNum == L_LAST) ? L_ONE : lineNum + L_ONE;
    end else begin
      wordNum <= wordNum + W_ONE;
    end
  end

  // Line and word decode into strobes.
  always_comb begin
    strb.lineActive = ((lineNum >= L_A1F) && (lineNum <= L_A1L)) ||
                      ((lineNum >= L_A2F) && (lineNum <= L_A2L));
    strb.fieldBit   = (lineNum < L_F1) || (lineNum >= L_F2);
    strb.sub        = wordNum[1:0];
    strb.syncEav    = wordNum < EAV_END;
    strb.syncSav    = (wordNum >= SAV_POS) && (wordNum < ACT_POS);
    strb.actSpan    = wordNum >= ACT_POS;
    strb.groupEnd   = wordNum[1:0] == 2'd3;
    strb.reqSlot    = strb.lineActive && (wordNum >= SAV_POS) &&
                      (wordNum <= LAST_REQ) && (wordNum[1:0] == 2'd0);
  end

  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (rst)
    wordNum == LAST_WORD |=> wordNum == '0);  // R1
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    wordNum != LAST_WORD |=> wordNum == $past(wordNum) + W_ONE);  // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wordNum == LAST_WORD && lineNum == L_LAST) |=> lineNum == L_ONE);  // R1
  AST_RESET_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wordNum == '0 && lineNum == L_ONE));  // R10
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb.reqSlot |=> !strb.reqSlot);  // R6

endmodule

// File: rtl/vid656_dpath.sv
module vid656_dpath import vid656_pkg::*; #(
  parameter int GROUP_WORDS = 4,
  parameter int WORD_BITS   = 8,
  localparam int PIX_W      = GROUP_WORDS * WORD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  vidStrobe_t       strb,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic [7:0]       vidData
);

  logic             pending;   // request issued, answer not yet seen
  logic             gotData;   // answer held for the coming group
  logic             curValid;  // current group carries picture data
  logic [PIX_W-1:0] hold;
  logic [PIX_W-1:0] curPix;
  logic             accept;
  logic [7:0]       grpByte [GROUP_WORDS];

  assign accept = pixValid && (strb.reqSlot || pending);

  for (genvar b = 0; b < GROUP_WORDS; b++) begin : g_byte
    assign grpByte[b] = curPix[PIX_W-1-WORD_BITS*b -: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      gotData  <= 1'b0;
      curValid <= 1'b0;
      hold     <= '0;
      curPix   <= '0;
    end else if (strb.groupEnd) begin
      curPix   <= accept ? pixData : hold;
      curValid <= accept || gotData;
      pending  <= 1'b0;
      gotData  <= 1'b0;
    end else if (accept) begin
      hold    <= pixData;
      gotData <= 1'b1;
      pending <= 1'b0;
    end else if (strb.reqSlot) begin
      pending <= 1'b1;
    end
  end

  always_comb begin
    if (strb.syncEav || strb.syncSav) begin
      case (strb.sub)
        2'd0:    vidData = 8'hFF;
        2'd3:    vidData = timingWord(strb.fieldBit, !strb.lineActive, strb.syncEav);
        default: vidData = 8'h00;
      endcase
    end else if (strb.actSpan && strb.lineActive && curValid) begin
      vidData = grpByte[strb.sub];
    end else begin
      vidData = strb.sub[0] ? BLANK_LUMA : BLANK_CHROMA;
    end
  end

  AST_PIX_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    curValid |-> (strb.actSpan && strb.lineActive));  // R7
  AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (rst)
    pending |-> strb.sub != 2'd0);  // R9
  AST_BLANK_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (!strb.syncEav && !strb.syncSav && !curValid) |->
      (vidData == BLANK_CHROMA || vidData == BLANK_LUMA));  // R5

endmodule

// File: rtl/vid656_gen.sv
module vid656_gen import vid656_pkg::*; #(
  parameter int LINE_WORDS   = 1716,
  parameter int ACT_WORDS    = 1440,
  parameter int FRAME_LINES  = 525,
  parameter int FIELD1_FIRST = 4,
  parameter int FIELD2_FIRST = 266,
  parameter int ACT1_FIRST   = 20,
  parameter int ACT1_LAST    = 263,
  parameter int ACT2_FIRST   = 283,
  parameter int ACT2_LAST    = 525,
  parameter int WORD_W       = $clog2(LINE_WORDS),
  parameter int LINE_W       = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixValid,
  input  logic [31:0]       pixData,
  output logic              pixReq,
  output logic [7:0]        vidData,
  output logic [LINE_W-1:0] lineNum,
  output logic [WORD_W-1:0] wordNum
);

  vidStrobe_t strb;

  vid656_ctrl #(
    .LINE_WORDS(LINE_WORDS), .ACT_WORDS(ACT_WORDS), .FRAME_LINES(FRAME_LINES),
    .FIELD1_FIRST(FIELD1_FIRST), .FIELD2_FIRST(FIELD2_FIRST),
    .ACT1_FIRST(ACT1_FIRST), .ACT1_LAST(ACT1_LAST),
    .ACT2_FIRST(ACT2_FIRST), .ACT2_LAST(ACT2_LAST),
    .WORD_W(WORD_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strb(strb), .lineNum(lineNum), .wordNum(wordNum)
  );

  vid656_dpath #(.GROUP_WORDS(4), .WORD_BITS(8)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .pixValid(pixValid), .pixData(pixData), .vidData(vidData)
  );

  assign pixReq = strb.reqSlot;

  AST_EAV_LEAD: assert property (@(posedge clk) disable iff (rst)
    wordNum == '0 |-> vidData == 8'hFF);  // R2
  AST_XY_PROTECT: assert property (@(posedge clk) disable iff (rst)
    wordNum == WORD_W'(3) |-> (vidData[7] && vidData[3] == (vidData[5] ^ vidData[4]) &&
                               vidData[0] == (vidData[6] ^ vidData[5] ^ vidData[4])));  // R3
  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pixReq |-> wordNum[1:0] == 2'b00);  // R6

endmodule

// File: tb/vid656_gen_bench.sv
module vid656_gen_bench;
  localparam int CLK_PERIOD = 38;
  // Reduced raster so that whole frames fit in the run.
  localparam int LW = 64, AW = 40, FL = 25;
  localparam int F1F = 2, F2F = 14, A1F = 4, A1L = 12, A2F = 16, A2L = 25;
  localparam int SAVP = LW - AW - 4, ACTP = LW - AW, SCAN = LW * (FL + 1);
  localparam int M_D0 = 0, M_D1 = 1, M_D3 = 2, M_NONE = 3, M_ODD = 4, M_STRAY = 5;

  // Spot vectors {line, word, expected} under one-cycle answer delay.
  localparam int NV = 25;
  localparam logic [23:0] VEC [NV] = '{
    {8'd1, 8'd0, 8'hFF},  {8'd1, 8'd3, 8'hF1},  {8'd1, 8'd23, 8'hEC}, {8'd2, 8'd3, 8'hB6},
    {8'd3, 8'd23, 8'hAB}, {8'd4, 8'd3, 8'h9D},  {8'd4, 8'd4, 8'h80},  {8'd4, 8'd19, 8'h10},
    {8'd4, 8'd23, 8'h80}, {8'd4, 8'd24, 8'h00}, {8'd4, 8'd25, 8'h04}, {8'd4, 8'd26, 8'hFF},
    {8'd4, 8'd27, 8'hA5}, {8'd4, 8'd60, 8'h09}, {8'd4, 8'd63, 8'hA5}, {8'd12, 8'd61, 8'h0C},
    {8'd13, 8'd3, 8'hB6}, {8'd13, 8'd24, 8'h80}, {8'd13, 8'd25, 8'h10}, {8'd14, 8'd3, 8'hF1},
    {8'd16, 8'd3, 8'hDA}, {8'd16, 8'd23, 8'hC7}, {8'd17, 8'd25, 8'h11}, {8'd25, 8'd62, 8'hF6},
    {8'd25, 8'd63, 8'hA5}
  };

  logic        clk, rst, pixValid, pixReq;
  logic [31:0] pixData;
  logic [7:0]  vidData;
  logic [4:0]  lineNum;
  logic [5:0]  wordNum;

  int nCmp, nBad, mode, cd, win, tagK, tagL;
  bit finished;

  vid656_gen #(
    .LINE_WORDS(LW), .ACT_WORDS(AW), .FRAME_LINES(FL),
    .FIELD1_FIRST(F1F), .FIELD2_FIRST(F2F),
    .ACT1_FIRST(A1F), .ACT1_LAST(A1L), .ACT2_FIRST(A2F), .ACT2_LAST(A2L)
  ) u_vid656_gen (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixData(pixData),
    .pixReq(pixReq), .vidData(vidData), .lineNum(lineNum), .wordNum(wordNum)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [31:0] mkPix(int k, int line);
    return {8'(k), 8'(line), ~8'(k), 8'hA5};
  endfunction

  function automatic bit isAct(int line);
    return (line >= A1F && line <= A1L) || (line >= A2F && line <= A2L);
  endfunction

  function automatic bit present(int m, int k);
    if (m == M_D0 || m == M_D1 || m == M_D3) return 1'b1;
    if (m == M_ODD) return (k % 2) == 0;
    return 1'b0;
  endfunction

  function automatic logic [7:0] expWord(int line, int w, int m);
    logic f, v, h;
    logic [31:0] p;
    int sub, k;
    sub = w % 4;
    f = (line < F1F) || (line >= F2F);
    v = !isAct(line);
    if (w < 4 || (w >= SAVP && w < ACTP)) begin
      h = (w < 4);
      if (sub == 0) return 8'hFF;
      if (sub == 3) return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      return 8'h00;
    end
    if (w >= ACTP && !v) begin
      k = (w - ACTP) / 4;
      if (present(m, k)) begin
        p = mkPix(k, line);
        return p[31 - 8 * sub -: 8];
      end
    end
    return (sub % 2 == 1) ? 8'h10 : 8'h80;
  endfunction

  function automatic string tagFor(int line, int w, int m);
    if (w < 4 || (w >= SAVP && w < ACTP)) return (w % 4 == 3) ? "R3/R4 XY" : "R2";
    if (w < ACTP || !isAct(line)) return "R5";
    if (m == M_NONE || (m == M_ODD && ((w - ACTP) / 4) % 2 == 1)) return "R8";
    if (m == M_STRAY) return "R9";
    return "R7";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h (line %0d word %0d)", req, act, exp, lineNum, wordNum);
    end
  endtask

  task automatic waitPos(int l, int w);
    while (!(int'(lineNum) == l && int'(wordNum) == w)) @(negedge clk);
  endtask

  task automatic scanNow(int m);
    for (int i = 0; i < SCAN; i++) begin
      int line, w;
      bit er;
      line = (i / LW) % FL + 1;
      w = i % LW;
      er = isAct(line) && w >= SAVP && w <= LW - 8 && (w % 4 == 0);
      chk("R1 line", 32'(lineNum), 32'(line));
      chk("R1 word", 32'(wordNum), 32'(w));
      chk(tagFor(line, w, m), 32'(vidData), 32'(expWord(line, w, m)));
      chk("R6 req", 32'(pixReq), 32'(er));
      @(negedge clk);
    end
  endtask

  task automatic runScan(int m);
    waitPos(1, 0);
    mode = m;
    scanNow(m);
  endtask

  // Frame-buffer reader model.
  initial begin
    pixValid = 1'b0;
    pixData = '0;
    cd = -1;
    win = 0;
    forever begin
      @(negedge clk);
      pixValid = 1'b0;
      pixData = '0;
      if (pixReq) begin
        tagK = (int'(wordNum) - SAVP) / 4;
        tagL = int'(lineNum);
        win = 4;
        case (mode)
          M_D0:    cd = 0;
          M_D1:    cd = 1;
          M_D3:    cd = 3;
          M_ODD:   cd = (tagK % 2 == 0) ? 1 : -1;
          default: cd = -1;
        endcase
      end
      if (cd == 0) begin
        pixValid = 1'b1;
        pixData = mkPix(tagK, tagL);
      end
      if (mode == M_STRAY && win == 0 && !pixReq) begin
        pixValid = 1'b1;
        pixData = 32'hDEADBEEF;
      end
      if (cd >= 0) cd--;
      if (win > 0) win--;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    nCmp = 0;
    nBad = 0;
    finished = 1'b0;
    mode = M_D1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 line", 32'(lineNum), 32'd1);
    chk("R10 word", 32'(wordNum), 32'd0);
    chk("R10 data", 32'(vidData), 32'hFF);
    chk("R10 req", 32'(pixReq), 32'd0);
    rst = 1'b0;

    // Spot table walked through one frame.
    for (int i = 0; i < NV; i++) begin
      int tl, tw;
      tl = int'(VEC[i][23:16]);
      tw = int'(VEC[i][15:8]);
      waitPos(tl, tw);
      chk(tagFor(tl, tw, M_D1), 32'(vidData), 32'(VEC[i][7:0]));
    end

    // Whole frames under each answer pattern.
    runScan(M_D0);
    runScan(M_D3);
    runScan(M_NONE);
    runScan(M_ODD);
    runScan(M_STRAY);

    // Reset in the middle of an active line.
    mode = M_D1;
    waitPos(5, 30);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 line", 32'(lineNum), 32'd1);
    chk("R10 word", 32'(wordNum), 32'd0);
    chk("R10 req", 32'(pixReq), 32'd0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 data", 32'(vidData), 32'hFF);
    scanNow(M_D1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule